// File: doc/BRIEF.md
# Hot-Plug Slot System-Error Status

This block keeps the system-error status for a six-slot hot-plug controller. It has two status registers, each one bit per slot. The fault register records power faults seen on slots that are attached to the bus. The switch register records switch events that a slot has redirected to the system-error path. The block also keeps a pending-interrupt bit for each slot. Any switch event sets that bit. It is cleared by its own acknowledge input, or by clearing the matching redirected switch-status bit.

Software reaches both registers through a small port: one select bit, a single-cycle write strobe and an 8-bit write-data bus. A write clears each bit where the data holds a one. A read returns a registered copy of the selected register one cycle later. The system-error request output is raised while any status bit in either register is set.

Top module: `slot_serr_status`

## Requirements
- R1: After reset, both status registers, `intPending`, `serrReq` and `rdData` are all zero.
- R2: Bits 7:6 of `rdData` always read as zero, even after a write of FFh.
- R3: Fault-status bit i sets only when all of these are true in the same cycle: `pwrFaultPulse[i]`=1, `slotConnected[i]`=1, `pfFuncEn`=1 and `pfSerrEn`=1.
- R4: Switch-status bit i sets only when `swChangePulse[i]`=1, `intRedirect[i]`=1 and `intMask[i]`=0.
- R5: A write (`regWrEn`=1) clears each status bit of the selected register whose `regWrData` bit is 1. Data bits of 0 leave bits unchanged.
- R6: Clearing a switch-status bit that was 1 also clears `intPending` for that slot in the same cycle.
- R7: Writes to the fault register, and fault events, never change `intPending`.
- R8: `serrReq` is 1 exactly when at least one bit of either status register is 1.
- R9: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set. The same applies to `intPending` when a switch event meets an acknowledge or a clear.
- R10: `swChangePulse[i]` sets `intPending[i]` whether or not the event is redirected. `intAck[i]`=1 clears it.
- R11: `regSel`=0 selects the fault register and `regSel`=1 selects the switch register. Slot A is bit 0 and slot F is bit 5. `rdData` shows the selected register's value from before the edge, one cycle after the select is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrFaultPulse | input | 6 | Per-slot power-fault event, one-cycle pulse |
| swChangePulse | input | 6 | Per-slot switch-change event, one-cycle pulse |
| slotConnected | input | 6 | Slot is attached to the bus or clock |
| pfFuncEn | input | 1 | Power-fault function enable |
| pfSerrEn | input | 1 | Report power faults as system error |
| intRedirect | input | 6 | Per-slot switch interrupt redirected to system error |
| intMask | input | 6 | Per-slot interrupt mask |
| intAck | input | 6 | Per-slot pending-interrupt acknowledge |
| regSel | input | 1 | Register select: 0 fault, 1 switch |
| regWrEn | input | 1 | Single-cycle write strobe |
| regWrData | input | 8 | Write data, one-to-clear |
| rdData | output | 8 | Registered read data |
| serrReq | output | 1 | System-error request |
| intPending | output | 6 | Per-slot pending interrupt |

## Verification
The hardest case to reach is one cycle in which a switch event, an acknowledge and a clear of the same slot all land together, since they are separate inputs. The same is true when a fault arrives while software clears the fault register. Directed phases build these collisions on purpose. A long random phase then drives all event, qualifier, acknowledge and write inputs at high density. The bench's behavioural model is compared with `rdData`, `serrReq` and `intPending` on every clock. `regSel` alternates during this phase so that both registers are seen through the port.

// File: rtl/serr_pkg.sv
package serr_pkg;
  localparam int SLOT_COUNT = 6;
  localparam int REG_WIDTH  = 8;

  // Strobes from control to datapath, one bit per slot
  typedef struct packed {
    logic [SLOT_COUNT-1:0] pfSet;
    logic [SLOT_COUNT-1:0] pfClr;
    logic [SLOT_COUNT-1:0] swSet;
    logic [SLOT_COUNT-1:0] swClr;
    logic [SLOT_COUNT-1:0] intSet;
    logic [SLOT_COUNT-1:0] intClr;
  } serr_strobe_t;
endpackage

// File: rtl/serr_ctrl.sv
module serr_ctrl
  import serr_pkg::*;
(
  input  logic [SLOT_COUNT-1:0] pwrFaultPulse,
  input  logic [SLOT_COUNT-1:0] swChangePulse,
  input  logic [SLOT_COUNT-1:0] slotConnected,
  input  logic                  pfFuncEn,
  input  logic                  pfSerrEn,
  input  logic [SLOT_COUNT-1:0] intRedirect,
  input  logic [SLOT_COUNT-1:0] intMask,
  input  logic [SLOT_COUNT-1:0] intAck,
  input  logic                  regSel,
  input  logic                  regWrEn,
  input  logic [REG_WIDTH-1:0]  regWrData,
  input  logic [SLOT_COUNT-1:0] swStatus,
  output serr_strobe_t          stb
);
  logic                  pfQual;
  logic [SLOT_COUNT-1:0] wrMask;

  assign pfQual = pfFuncEn & pfSerrEn;
  assign wrMask = regWrEn ? regWrData[SLOT_COUNT-1:0] : '0;

  always_comb begin
    stb.pfSet  = pwrFaultPulse & slotConnected & {SLOT_COUNT{pfQual}};
    stb.swSet  = swChangePulse & intRedirect & ~intMask;
    stb.pfClr  = regSel ? '0 : wrMask;
    stb.swClr  = regSel ? wrMask : '0;
    stb.intSet = swChangePulse;
    // only a real clear of a set switch bit drops the interrupt
    stb.intClr = intAck | (stb.swClr & swStatus);
  end
endmodule

// File: rtl/serr_datapath.sv
module serr_datapath
  import serr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  serr_strobe_t          stb,
  input  logic                  regSel,
  output logic [SLOT_COUNT-1:0] pfStatus,
  output logic [SLOT_COUNT-1:0] swStatus,
  output logic [SLOT_COUNT-1:0] intPending,
  output logic [REG_WIDTH-1:0]  rdData,
  output logic                  serrReq
);
  localparam int PadW = REG_WIDTH - SLOT_COUNT;

  // one flop per slot per register; set has priority over clear
  for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pfStatus[i]   <= 1'b0;
        swStatus[i]   <= 1'b0;
        intPending[i] <= 1'b0;
      end else begin
        pfStatus[i]   <= stb.pfSet[i]  | (pfStatus[i]   & ~stb.pfClr[i]);
        swStatus[i]   <= stb.swSet[i]  | (swStatus[i]   & ~stb.swClr[i]);
        intPending[i] <= stb.intSet[i] | (intPending[i] & ~stb.intClr[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdData <= '0;
    else        rdData <= {{PadW{1'b0}}, (regSel ? swStatus : pfStatus)};
  end

  assign serrReq = (|pfStatus) | (|swStatus);
endmodule

// File: rtl/slot_serr_status.sv
module slot_serr_status
  import serr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOT_COUNT-1:0] pwrFaultPulse,
  input  logic [SLOT_COUNT-1:0] swChangePulse,
  input  logic [SLOT_COUNT-1:0] slotConnected,
  input  logic                  pfFuncEn,
  input  logic                  pfSerrEn,
  input  logic [SLOT_COUNT-1:0] intRedirect,
  input  logic [SLOT_COUNT-1:0] intMask,
  input  logic [SLOT_COUNT-1:0] intAck,
  input  logic                  regSel,
  input  logic                  regWrEn,
  input  logic [REG_WIDTH-1:0]  regWrData,
  output logic [REG_WIDTH-1:0]  rdData,
  output logic                  serrReq,
  output logic [SLOT_COUNT-1:0] intPending
);
  serr_strobe_t          stb;
  logic [SLOT_COUNT-1:0] pfStatus;
  logic [SLOT_COUNT-1:0] swStatus;

  serr_ctrl u_ctrl (
    .pwrFaultPulse(pwrFaultPulse), .swChangePulse(swChangePulse),
    .slotConnected(slotConnected), .pfFuncEn(pfFuncEn), .pfSerrEn(pfSerrEn),
    .intRedirect(intRedirect), .intMask(intMask), .intAck(intAck),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .swStatus(swStatus), .stb(stb)
  );

  serr_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .regSel(regSel),
    .pfStatus(pfStatus), .swStatus(swStatus), .intPending(intPending),
    .rdData(rdData), .serrReq(serrReq)
  );
endmodule

// File: rtl/slot_serr_checker.sv
module slot_serr_checker
  import serr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [SLOT_COUNT-1:0] pwrFaultPulse,
  input logic [SLOT_COUNT-1:0] swChangePulse,
  input logic [SLOT_COUNT-1:0] slotConnected,
  input logic                  pfFuncEn,
  input logic                  pfSerrEn,
  input logic [SLOT_COUNT-1:0] intRedirect,
  input logic [SLOT_COUNT-1:0] intMask,
  input logic [SLOT_COUNT-1:0] intAck,
  input logic [REG_WIDTH-1:0]  rdData,
  input logic [SLOT_COUNT-1:0] intPending,
  input logic [SLOT_COUNT-1:0] pfStatus,
  input logic [SLOT_COUNT-1:0] swStatus
);
  logic [SLOT_COUNT-1:0] pfQual;
  logic [SLOT_COUNT-1:0] swQual;
  assign pfQual = pwrFaultPulse & slotConnected & {SLOT_COUNT{pfFuncEn & pfSerrEn}};
  assign swQual = swChangePulse & intRedirect & ~intMask;

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[REG_WIDTH-1:SLOT_COUNT] == '0); // R2

  AST_PF_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (pfStatus & ~$past(pfStatus) & ~$past(pfQual)) == '0); // R3

  AST_PF_QUAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pfStatus & $past(pfQual)) == $past(pfQual)); // R9

  AST_SW_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (swStatus & ~$past(swStatus) & ~$past(swQual)) == '0); // R4

  AST_INT_RISE_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (intPending & ~$past(intPending) & ~$past(swChangePulse)) == '0); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (intPending & $past(intAck & ~swChangePulse)) == '0); // R10
endmodule

bind slot_serr_status slot_serr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pwrFaultPulse(pwrFaultPulse),
  .swChangePulse(swChangePulse), .slotConnected(slotConnected),
  .pfFuncEn(pfFuncEn), .pfSerrEn(pfSerrEn), .intRedirect(intRedirect),
  .intMask(intMask), .intAck(intAck), .rdData(rdData),
  .intPending(intPending), .pfStatus(pfStatus), .swStatus(swStatus)
);

// File: tb/test_slot_serr_status.sv
`timescale 1ns/1ps
module test_slot_serr_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pwrFaultPulse = '0, swChangePulse = '0, slotConnected = '0;
  logic       pfFuncEn = 1'b0, pfSerrEn = 1'b0;
  logic [5:0] intRedirect = '0, intMask = '0, intAck = '0;
  logic       regSel = 1'b0, regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] rdData;
  logic       serrReq;
  logic [5:0] intPending;

  int tests = 0, fails = 0;
  string curTag = "R1";

  // behavioural reference state
  logic [5:0] mPf = '0, mSw = '0, mInt = '0;
  logic [7:0] mRd = '0;

  always #5 clk = ~clk;

  slot_serr_status i_slot_serr_status (
    .clk(clk), .rst_n(rst_n), .pwrFaultPulse(pwrFaultPulse),
    .swChangePulse(swChangePulse), .slotConnected(slotConnected),
    .pfFuncEn(pfFuncEn), .pfSerrEn(pfSerrEn), .intRedirect(intRedirect),
    .intMask(intMask), .intAck(intAck), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .rdData(rdData), .serrReq(serrReq),
    .intPending(intPending)
  );

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("rdData", rdData, mRd);
    check("serrReq", {7'b0, serrReq}, {7'b0, (mPf != 0) || (mSw != 0)});
    check("intPending", {2'b0, intPending}, {2'b0, mInt});
  endtask

  // advance one clock: update the model from the inputs, then compare
  task automatic cycle();
    logic [5:0] clrPf, clrSw, pfHit, swHit;
    @(posedge clk);
    if (rst_n) begin
      clrPf = (regWrEn && !regSel) ? regWrData[5:0] : 6'd0;
      clrSw = (regWrEn &&  regSel) ? regWrData[5:0] : 6'd0;
      pfHit = 6'd0; swHit = 6'd0;
      for (int i = 0; i < 6; i++) begin
        if (pwrFaultPulse[i] && slotConnected[i] && pfFuncEn && pfSerrEn) pfHit[i] = 1'b1;
        if (swChangePulse[i] && intRedirect[i] && !intMask[i]) swHit[i] = 1'b1;
      end
      mRd = regSel ? {2'b00, mSw} : {2'b00, mPf};
      for (int i = 0; i < 6; i++) begin
        if (intAck[i] || (clrSw[i] && mSw[i])) mInt[i] = 1'b0;
        if (swChangePulse[i]) mInt[i] = 1'b1;
        if (clrPf[i]) mPf[i] = 1'b0;
        if (pfHit[i]) mPf[i] = 1'b1;
        if (clrSw[i]) mSw[i] = 1'b0;
        if (swHit[i]) mSw[i] = 1'b1;
      end
    end
    #1;
    compareAll();
    pwrFaultPulse = '0; swChangePulse = '0; intAck = '0; regWrEn = 1'b0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    regSel = sel; regWrEn = 1'b1; regWrData = d;
    cycle();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    curTag = "R1";
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();

    // R3: fault qualifiers, one missing at a time
    curTag = "R3";
    slotConnected = 6'h3F; pfFuncEn = 1'b0; pfSerrEn = 1'b1;
    pwrFaultPulse = 6'h01; cycle();
    pfFuncEn = 1'b1; pfSerrEn = 1'b0; pwrFaultPulse = 6'h02; cycle();
    pfSerrEn = 1'b1; slotConnected = 6'h1F; pwrFaultPulse = 6'h20; cycle();
    slotConnected = 6'h3F; pwrFaultPulse = 6'h21; cycle();
    cycle();
    check("R3 fault reg slots A,F", rdData, 8'h21);

    // R7: fault events and fault writes leave interrupts alone
    curTag = "R7";
    check("R7 no pending from faults", {2'b0, intPending}, 8'h00);

    // R4: switch qualifiers
    curTag = "R4";
    regSel = 1'b1;
    intRedirect = 6'h0F; intMask = 6'h05;
    swChangePulse = 6'h3F; cycle();
    cycle();
    check("R4 switch reg", rdData, 8'h0A);
    // R10: all slots pending regardless of redirect
    curTag = "R10";
    check("R10 pending all", {2'b0, intPending}, 8'h3F);
    intAck = 6'h30; cycle();
    check("R10 ack clears F,E", {2'b0, intPending}, 8'h0F);

    // R5: zero writes do nothing, one writes clear
    curTag = "R5";
    wr(1'b1, 8'h00); wr(1'b1, 8'h02); regWrEn = 1'b0; cycle();
    check("R5 switch after clear", rdData, 8'h08);

    // R6: clearing switch bit drops its interrupt; clearing a 0 bit does not
    curTag = "R6";
    check("R6 pending after clear", {2'b0, intPending}, 8'h0D);
    wr(1'b1, 8'h01);
    check("R6 clear of unset bit keeps pending", {2'b0, intPending}, 8'h0D);

    // R7: fault clear does not touch interrupts
    curTag = "R7";
    wr(1'b0, 8'h01);
    check("R7 pending unchanged", {2'b0, intPending}, 8'h0D);

    // R9: set wins over clear
    curTag = "R9";
    regSel = 1'b0; regWrEn = 1'b1; regWrData = 8'h20; pwrFaultPulse = 6'h20; cycle();
    regSel = 1'b1; regWrEn = 1'b1; regWrData = 8'h08; swChangePulse = 6'h08;
    intAck = 6'h08; cycle();
    check("R9 pending kept", {2'b0, intPending}, 8'h0D);
    regSel = 1'b0; cycle(); cycle();
    check("R9 fault reg", rdData, 8'h20);

    // R2: writes of FF keep reserved bits zero; R8 drops once all clear
    curTag = "R2";
    wr(1'b0, 8'hFF); wr(1'b1, 8'hFF); cycle();
    check("R2 reserved", {rdData[7:6], 6'b0}, 8'h00);
    curTag = "R8";
    check("R8 serr low", {7'b0, serrReq}, 8'h00);
    pwrFaultPulse = 6'h04; cycle();
    check("R8 serr high", {7'b0, serrReq}, 8'h01);

    // R11: random traffic, both registers read in turn
    curTag = "R11";
    for (int n = 0; n < 3000; n++) begin
      pwrFaultPulse = 6'($urandom); swChangePulse = 6'($urandom) & 6'($urandom);
      slotConnected = 6'($urandom); pfFuncEn = ($urandom % 4) != 0;
      pfSerrEn = ($urandom % 4) != 0; intRedirect = 6'($urandom);
      intMask = 6'($urandom); intAck = 6'($urandom) & 6'($urandom) & 6'($urandom);
      regSel = n[0]; regWrEn = ($urandom % 3) == 0; regWrData = 8'($urandom);
      cycle();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule